// File: doc/BRIEF.md
# Oversampled Serial Byte Transmitter

This block sends one 8-bit byte over a single asynchronous serial line. It runs on the system clock. A one-cycle `sample_tick` enable arrives sixteen times per bit period, and nothing inside the block advances on a clock edge where the tick is low. Each frame has three parts, in this order:

1. a low start bit;
2. the eight data bits, least significant bit first;
3. a high stop bit.

Every bit is held on the line for sixteen ticks.

To request a frame, the user raises `tx_valid` with the byte on `tx_byte`. The request must stay present for a full bit period of sixteen consecutive ticks before the block leaves idle. At that moment the byte is copied into an internal shift register, so the input bus and the valid line may change freely while the frame goes out. When the stop bit ends, the block returns to idle. It then needs a fresh sixteen-tick qualification before it sends again.

Top module: `uart_serial_tx`

## Requirements
- R1: Asserting `rst` forces `tx_line` high at once, without waiting for a clock edge. It also returns the block to idle and clears the tick counter and the bit counter, so that after release a full qualification is needed again.
- R2: In idle, `tx_line` is high. `tx_valid` is sampled only on clock edges where `sample_tick` is 1. On the edge of the sixteenth consecutive such tick with `tx_valid` = 1, `tx_line` goes low to begin the start bit.
- R3: While idle, a tick that sees `tx_valid` = 0 restarts the qualification count from zero. Sixteen new consecutive high ticks are then needed.
- R4: The start bit (`tx_line` = 0) lasts exactly sixteen ticks.
- R5: After the start bit, the eight bits of the byte appear on `tx_line`, bit 0 first and bit 7 last. Each bit lasts exactly sixteen ticks.
- R6: After bit 7 the line is high for a sixteen-tick stop bit, and the block then returns to idle. If `tx_valid` is still high, the next start bit begins sixteen ticks after the stop bit ends.
- R7: The byte is captured on the tick that ends qualification. Later changes to `tx_byte` or `tx_valid` do not alter the frame being sent.
- R8: On clock edges with `sample_tick` = 0, `tx_line` and all internal counters hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| sample_tick | input | 1 | One-cycle enable, sixteen per bit period |
| tx_valid | input | 1 | Transmit request, must be held for one bit period |
| tx_byte | input | 8 | Byte to send |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
Every line change is due on the clock edge of the tick that completes a sixteen-tick bit window. The start bit is due on the sixteenth qualifying tick. The line is decoded from registered state, so the result is visible one time step after that edge, with no further latency.

The bench counts ticks itself and samples `tx_line` just after each tick edge:
- On ticks one to fifteen of each window, the line must still show the current bit.
- On the sixteenth tick, the line must show the next bit.
- Two edges later, with no tick between, the value must be unchanged.

Reset is checked before any clock edge follows it, which confirms that it acts at once.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    parameter int unsigned TICKS_PER_BIT = 16;
    parameter int unsigned DATA_BITS     = 8;

    localparam int unsigned TICK_CW = $clog2(TICKS_PER_BIT);
    localparam int unsigned IDX_W   = $clog2(DATA_BITS);

    typedef logic [TICK_CW-1:0]   tick_cnt_t;
    typedef logic [IDX_W-1:0]     bit_idx_t;
    typedef logic [DATA_BITS-1:0] payload_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } tx_phase_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic qual_clear;
    } tx_ctrl_t;

    function automatic logic phase_level(tx_phase_e ph, logic lsb);
        case (ph)
            PH_START: return 1'b0;
            PH_DATA:  return lsb;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/utx_tick_counter.sv
module utx_tick_counter
    import uart_tx_pkg::*;
#(
    parameter int unsigned TICKS = TICKS_PER_BIT
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      clear,
    output tick_cnt_t cnt,
    output logic      window_end
);
    localparam tick_cnt_t LAST = tick_cnt_t'(TICKS - 1);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (clear || cnt == LAST) cnt <= '0;
            else                      cnt <= cnt + tick_cnt_t'(1);
        end
    end

    assign window_end = tick && !clear && (cnt == LAST);

    assert_tick_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    assert_clear_restarts_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && clear) |=> (cnt == '0));

endmodule

// File: rtl/utx_bit_index.sv
module utx_bit_index
    import uart_tx_pkg::*;
#(
    parameter int unsigned NBITS = DATA_BITS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     step,
    output bit_idx_t idx,
    output logic     on_last
);
    localparam bit_idx_t TOP = bit_idx_t'(NBITS - 1);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            if (idx == TOP) idx <= '0;
            else            idx <= idx + bit_idx_t'(1);
        end
    end

    assign on_last = (idx == TOP);

    assert_idx_moves_by_one_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && idx != TOP) |=> (idx == $past(idx) + bit_idx_t'(1)));

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import uart_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     shift,
    input  payload_t din,
    output logic     lsb
);
    payload_t sr;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sr <= '1;
        end else if (load) begin
            sr <= din;
        end else if (shift) begin
            sr <= {1'b1, sr[DATA_BITS-1:1]};
        end
    end

    assign lsb = sr[0];

    assert_capture_only_on_load_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(sr));

endmodule

// File: rtl/utx_fsm.sv
module utx_fsm
    import uart_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      valid,
    input  logic      window_end,
    input  logic      last_bit,
    output tx_phase_e phase,
    output tx_ctrl_t  ctrl
);
    tx_phase_e nxt;

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE:  if (window_end)             nxt = PH_START;
            PH_START: if (window_end)             nxt = PH_DATA;
            PH_DATA:  if (window_end && last_bit) nxt = PH_STOP;
            PH_STOP:  if (window_end)             nxt = PH_IDLE;
            default:                              nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        ctrl.qual_clear = (phase == PH_IDLE) && !valid;
        ctrl.load       = (phase == PH_IDLE) && window_end;
        ctrl.shift      = (phase == PH_DATA) && window_end;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    assert_idle_exit_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_START && $past(phase) == PH_IDLE) |-> ($past(valid) && $past(tick)));

    assert_idle_goes_to_start_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> (phase == PH_IDLE || phase == PH_START));

    assert_phase_needs_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase));

endmodule

// File: rtl/uart_serial_tx.sv
module uart_serial_tx
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_tick,
    input  logic       tx_valid,
    input  logic [7:0] tx_byte,
    output logic       tx_line
);
    tick_cnt_t tcnt;
    logic      win_end;
    bit_idx_t  bidx;
    logic      last_bit;
    logic      lsb;
    tx_phase_e phase;
    tx_ctrl_t  ctrl;

    utx_tick_counter #(.TICKS(TICKS_PER_BIT)) u_ticks (
        .clk        (clk),
        .rst        (rst),
        .tick       (sample_tick),
        .clear      (ctrl.qual_clear),
        .cnt        (tcnt),
        .window_end (win_end)
    );

    utx_bit_index #(.NBITS(DATA_BITS)) u_index (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctrl.load),
        .step    (ctrl.shift),
        .idx     (bidx),
        .on_last (last_bit)
    );

    utx_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (ctrl.load),
        .shift (ctrl.shift),
        .din   (payload_t'(tx_byte)),
        .lsb   (lsb)
    );

    utx_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (sample_tick),
        .valid      (tx_valid),
        .window_end (win_end),
        .last_bit   (last_bit),
        .phase      (phase),
        .ctrl       (ctrl)
    );

    assign tx_line = phase_level(phase, lsb);

    assert_eight_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STOP && $past(phase) == PH_DATA) |-> ($past(bidx) == bit_idx_t'(DATA_BITS - 1)));

    assert_stop_full_window_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && $past(phase) == PH_STOP) |-> ($past(tcnt) == tick_cnt_t'(TICKS_PER_BIT - 1)));

    assert_start_full_window_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) == PH_START) |-> ($past(tcnt) == tick_cnt_t'(TICKS_PER_BIT - 1) && bidx == '0));

endmodule

// File: tb/tb_uart_serial_tx.sv
`timescale 1ns/1ps
module tb_uart_serial_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_line;

    int checks = 0;
    int failures = 0;
    int divcnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        divcnt <= (divcnt == 3) ? 0 : divcnt + 1;
        sample_tick <= (divcnt == 2);
    end

    uart_serial_tx dut (
        .clk(clk), .rst(rst), .sample_tick(sample_tick),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_line(tx_line)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: tx_line=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!sample_tick);
        #1;
    endtask

    // current bit for 15 ticks, next bit on the 16th, unchanged two tick-free edges later
    task automatic hold(input logic now_v, input logic next_v, input string req);
        logic bad = 1'b0;
        for (int k = 0; k < 15; k++) begin
            wait_tick();
            if (tx_line !== now_v) bad = 1'b1;
        end
        chk(bad ? ~now_v : now_v, now_v, req);
        wait_tick();
        chk(tx_line, next_v, req);
        @(posedge clk); @(posedge clk); #1;
        chk(tx_line, next_v, "R8");
    endtask

    task automatic send_frame(input logic [7:0] d, input bit keep_valid);
        tx_byte = d; tx_valid = 1'b1;
        hold(1'b1, 1'b0, "R2");
        tx_byte = ~d;                       // R7: input change must not leak
        if (!keep_valid) tx_valid = 1'b0;
        hold(1'b0, d[0], "R4");
        for (int i = 0; i < 8; i++)
            hold(d[i], (i < 7) ? d[i+1] : 1'b1, "R5_R7");
        if (keep_valid) hold(1'b1, 1'b1, "R6");
        else            hold(1'b1, 1'b1, "R6");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk(tx_line, 1'b1, "R1");
        rst = 1'b0;
    endtask

    task automatic t_frames();
        send_frame(8'hA5, 1'b0);
        for (int k = 0; k < 20; k++) wait_tick();
        chk(tx_line, 1'b1, "R2");
        send_frame(8'h3C, 1'b0);
        send_frame(8'h01, 1'b0);
    endtask

    task automatic t_back_to_back();
        send_frame(8'hC3, 1'b1);
        // still valid: 16 ticks of idle, then a new start bit (R6)
        tx_byte = 8'hF0;
        hold(1'b1, 1'b0, "R6");
        tx_valid = 1'b0;
        hold(1'b0, 1'b0, "R4");
        for (int i = 0; i < 8; i++)
            hold(tx_byte[i], (i < 7) ? tx_byte[i+1] : 1'b1, "R5");
        hold(1'b1, 1'b1, "R6");
    endtask

    task automatic t_abort_qual();
        tx_byte = 8'h5A; tx_valid = 1'b1;
        for (int k = 0; k < 10; k++) wait_tick();
        tx_valid = 1'b0;
        wait_tick();
        chk(tx_line, 1'b1, "R3");
        tx_valid = 1'b1;
        for (int k = 0; k < 15; k++) wait_tick();
        chk(tx_line, 1'b1, "R3");
        wait_tick();
        chk(tx_line, 1'b0, "R3");
        tx_valid = 1'b0;
        for (int k = 0; k < 16 * 10; k++) wait_tick();
        chk(tx_line, 1'b1, "R3");
    endtask

    task automatic t_async_reset();
        tx_byte = 8'h00; tx_valid = 1'b1;
        for (int k = 0; k < 16 + 16 + 3; k++) wait_tick();
        tx_valid = 1'b0;
        chk(tx_line, 1'b0, "R1");
        rst = 1'b1;
        #0.5;
        chk(tx_line, 1'b1, "R1");
        for (int k = 0; k < 3; k++) wait_tick();
        rst = 1'b0;
        chk(tx_line, 1'b1, "R1");
        send_frame(8'h96, 1'b0);
    endtask

    initial begin
        t_reset();
        t_frames();
        t_abort_qual();
        t_back_to_back();
        t_async_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule